// File: doc/BRIEF.md
# Byte-Loaded Dual Channel DAC Code Register

This block holds the digital codes for two 12-bit converter channels and fills them from an 8-bit processor bus. Each channel keeps a staging register, filled a byte or nibble at a time, and a separate live register whose value is presented downstream as the channel code. The staging register of a channel is split into a low byte and a high nibble; two address bits pick one of the four pieces, and a write happens while chip select and write strobe are both low.

A shared active-low load strobe, independent of chip select and write, moves both staging registers into both live registers together. While the load strobe is low the live registers track the staging registers; when it rises they hold. All bus pins are brought into the system clock through two-flop synchronisers, with address and data delayed by the same number of stages so they stay aligned with the strobes.

Top module: `dac_pair_loader`

## Requirements
- R1: After reset both staging and both live registers are zero, so both output codes read 0x000.
- R2: With chip select and write low, address 2'b00 loads bus bits 7..0 into channel A code bits 7..0, leaving bits 11..8 unchanged.
- R3: Address 2'b01 loads bus bits 3..0 into channel A code bits 11..8; bus bits 7..4 are ignored and bits 7..0 are unchanged.
- R4: Addresses 2'b10 and 2'b11 load the low byte and the high nibble of channel B in the same way, leaving channel A untouched.
- R5: While chip select is high, or write is high, no staging register changes.
- R6: The low byte and high nibble of a channel may be written in either order with the same resulting code.
- R7: While the load strobe stays high, writes to staging registers never change either output code.
- R8: While the load strobe is low, both output codes follow their staging registers, including writes made during that time.
- R9: After the load strobe rises, both output codes hold their values through later writes.
- R10: A load that overlaps a write and stays low for at least four clock cycles after the write ends leaves the final written data on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select, active low, asynchronous |
| wrN | input | 1 | Write strobe, active low, asynchronous |
| ldN | input | 1 | Load strobe for both channels, active low, asynchronous |
| addr | input | 2 | Piece select: bit 1 channel (0 A, 1 B), bit 0 part (0 low byte, 1 high nibble) |
| busData | input | 8 | Right-justified bus data |
| codeA | output | 12 | Live code of channel A |
| codeB | output | 12 | Live code of channel B |

## Verification
Random write traffic covers all four addresses with chip select and write each sometimes inactive, which separates a missing strobe qualification from a wrong address decode, interleaved with load pulses that reveal whether staging data leaks into the outputs early. Directed cases write the two halves in both orders and put ones in the ignored upper nibble bits, telling a wrong nibble mapping apart from an order dependence. Writes made during a held-low load and a load that outlasts a write show whether the live registers track continuously or only sample once.

// File: rtl/dac_pair_pkg.sv
package dac_pair_pkg;
  localparam int CODE_W = 12;
  localparam int BUS_W  = 8;
  localparam int NUM_CH = 2;
  localparam int HI_W   = CODE_W - BUS_W;

  typedef struct packed {
    logic [NUM_CH-1:0] wrLo;
    logic [NUM_CH-1:0] wrHi;
    logic              load;
  } strobe_t;
endpackage

// File: rtl/dac_pair_ctrl.sv
module dac_pair_ctrl
  import dac_pair_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csN,
  input  logic             wrN,
  input  logic             ldN,
  input  logic [1:0]       addr,
  input  logic [BUS_W-1:0] busData,
  output strobe_t          strb,
  output logic [BUS_W-1:0] dataQ
);
  localparam int VW = 3 + 2 + BUS_W;
  localparam logic [VW-1:0] RST_VAL = {3'b111, {(2 + BUS_W){1'b0}}};

  logic [VW-1:0] pipe [STAGES];
  logic [VW-1:0] rawIn;
  assign rawIn = {csN, wrN, ldN, addr, busData};

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe[s] <= RST_VAL;
        else if (s == 0) pipe[s] <= rawIn;
        else pipe[s] <= pipe[(s == 0) ? 0 : s - 1];
      end
    end
  endgenerate

  logic       csQ, wrQ, ldQ;
  logic [1:0] addrQ;
  logic       wrAct;
  assign {csQ, wrQ, ldQ, addrQ, dataQ} = pipe[STAGES-1];
  assign wrAct = !csQ && !wrQ;

  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_dec
      assign strb.wrLo[c] = wrAct && (addrQ[1] == c[0]) && !addrQ[0];
      assign strb.wrHi[c] = wrAct && (addrQ[1] == c[0]) &&  addrQ[0];
    end
  endgenerate
  assign strb.load = !ldQ;

  // R2 R3 R4
  wr_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrLo, strb.wrHi}));

  // R5
  cs_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    csQ |-> ({strb.wrLo, strb.wrHi} == '0));
endmodule

// File: rtl/dac_pair_data.sv
module dac_pair_data
  import dac_pair_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [BUS_W-1:0]  dataQ,
  output logic [CODE_W-1:0] codes [NUM_CH]
);
  logic [CODE_W-1:0] stage [NUM_CH];

  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_ch
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          stage[c] <= '0;
        end else if (strb.wrLo[c]) begin
          stage[c][BUS_W-1:0] <= dataQ;
        end else if (strb.wrHi[c]) begin
          stage[c][CODE_W-1:BUS_W] <= dataQ[HI_W-1:0];
        end
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) codes[c] <= '0;
        else if (strb.load) codes[c] <= stage[c];
      end

      // R7 R9
      out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
        !strb.load |=> $stable(codes[c]));

      // R5
      stage_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
        !(strb.wrLo[c] || strb.wrHi[c]) |=> $stable(stage[c]));

      // R3
      hi_keep_low_chk: assert property (@(posedge clk) disable iff (!rstN)
        strb.wrHi[c] |=> $stable(stage[c][BUS_W-1:0]));

      // R2
      lo_keep_high_chk: assert property (@(posedge clk) disable iff (!rstN)
        strb.wrLo[c] |=> $stable(stage[c][CODE_W-1:BUS_W]));
    end
  endgenerate
endmodule

// File: rtl/dac_pair_loader.sv
module dac_pair_loader
  import dac_pair_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              wrN,
  input  logic              ldN,
  input  logic [1:0]        addr,
  input  logic [BUS_W-1:0]  busData,
  output logic [CODE_W-1:0] codeA,
  output logic [CODE_W-1:0] codeB
);
  strobe_t           strb;
  logic [BUS_W-1:0]  dataQ;
  logic [CODE_W-1:0] codes [NUM_CH];

  dac_pair_ctrl #(.STAGES(2)) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .wrN(wrN), .ldN(ldN),
    .addr(addr), .busData(busData), .strb(strb), .dataQ(dataQ)
  );

  dac_pair_data u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .dataQ(dataQ), .codes(codes)
  );

  assign codeA = codes[0];
  assign codeB = codes[1];
endmodule

// File: tb/sim_dac_pair_loader.sv
`timescale 1ns/1ps
module sim_dac_pair_loader;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, wrN = 1'b1, ldN = 1'b1;
  logic [1:0] addr = '0;
  logic [7:0] busData = '0;
  logic [11:0] codeA, codeB;

  int checks = 0;
  int errors = 0;
  logic [11:0] mIn [2];
  logic [11:0] mOut [2];

  always #2.5 clk = ~clk;

  dac_pair_loader u0 (
    .clk(clk), .rstN(rstN), .csN(csN), .wrN(wrN), .ldN(ldN),
    .addr(addr), .busData(busData), .codeA(codeA), .codeB(codeB)
  );

  function automatic logic [11:0] merge(input logic [11:0] old,
                                        input logic hi, input logic [7:0] d);
    if (hi) return {d[3:0], old[7:0]};
    return {old[11:4+4], d};
  endfunction

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(input string tag);
    checks++;
    if (codeA !== mOut[0] || codeB !== mOut[1]) begin
      errors++;
      $display("FAIL %s: codeA=%h codeB=%h expected %h %h",
               tag, codeA, codeB, mOut[0], mOut[1]);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d,
                          input logic cs, input logic wr);
    @(negedge clk);
    addr = a; busData = d; csN = cs; wrN = wr;
    waitCyc(4);
    csN = 1'b1; wrN = 1'b1;
    if (!cs && !wr) mIn[a[1]] = merge(mIn[a[1]], a[0], d);
    if (!ldN) mOut = mIn;
    waitCyc(5);
  endtask

  task automatic loadPulse();
    @(negedge clk);
    ldN = 1'b0;
    waitCyc(4);
    ldN = 1'b1;
    mOut = mIn;
    waitCyc(5);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    int seed;
    seed = $urandom(32'd4242);
    mIn[0] = '0; mIn[1] = '0; mOut[0] = '0; mOut[1] = '0;
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(3);
    check("R1 reset");

    // R2, R3 with ignored upper nibble bits, R7 outputs held
    busWrite(2'b00, 8'h5A, 1'b0, 1'b0);
    busWrite(2'b01, 8'hF3, 1'b0, 1'b0);
    check("R7 no load");
    loadPulse();
    check("R2 R3 A low/high");
    // R4 channel B, R6 reverse order
    busWrite(2'b11, 8'hAC, 1'b0, 1'b0);
    busWrite(2'b10, 8'h81, 1'b0, 1'b0);
    loadPulse();
    check("R4 R6 B high first");
    // R5 blocked writes
    busWrite(2'b00, 8'h00, 1'b1, 1'b0);
    busWrite(2'b10, 8'hFF, 1'b0, 1'b1);
    loadPulse();
    check("R5 blocked");
    // R8 follow while low, R9 hold after rise
    @(negedge clk); ldN = 1'b0; waitCyc(4);
    busWrite(2'b00, 8'h77, 1'b0, 1'b0);
    check("R8 follow low");
    busWrite(2'b11, 8'h09, 1'b0, 1'b0);
    check("R8 follow B");
    ldN = 1'b1; waitCyc(4);
    busWrite(2'b01, 8'h02, 1'b0, 1'b0);
    check("R9 hold after rise");
    // R10 overlap: load low before write, kept low after write ends
    @(negedge clk); ldN = 1'b0;
    addr = 2'b10; busData = 8'h3C; csN = 1'b0; wrN = 1'b0;
    waitCyc(3);
    csN = 1'b1; wrN = 1'b1;
    mIn[1] = merge(mIn[1], 1'b0, 8'h3C);
    waitCyc(4);
    ldN = 1'b1;
    mOut = mIn;
    waitCyc(5);
    check("R10 overlap");

    // random traffic
    for (int k = 0; k < 300; k++) begin
      if ($urandom % 4 == 0) begin
        loadPulse();
        check("R8 random load");
      end else begin
        busWrite(2'($urandom), 8'($urandom),
                 ($urandom % 5 == 0), ($urandom % 5 == 0));
        check("R7 random write");
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule